// File: doc/BRIEF.md
# Windowed Threshold Interrupt with Persistence Filter

This block sits behind a light-sensing converter and decides when the host should be interrupted. At the end of every integration period it receives one 16-bit result with a strobe. It tests whether that result lies outside a window set by a low and a high threshold, and counts how many such results arrive in an unbroken run. It raises an active-low interrupt once the run is long enough for the programmed persistence setting.

An 8-bit configuration register selects the persistence length and one of four modes: off, level, alert, or software-forced alert. A level interrupt stays asserted until the host issues a clear command. An alert interrupt also drives an alert-pending flag and is dropped only when the bus side reports that an alert-response transfer has completed. The comparison uses only the one result stream fed to the block. The serial bus and the converter lie outside the block.

Top module: `win_irq_filter`

## Requirements
- R1: After reset `irq_n` is 1, `alert_pend` is 0 and `ctl_q` reads 0x00.
- R2: A pulse on `ctl_wr` stores `ctl_wdata[5:0]` into the configuration register: bits 5:4 are the mode and bits 3:0 are the persistence length. `ctl_q[7:6]` always read as 0.
- R3: A result is out of window only when it is strictly less than `thr_lo` or strictly greater than `thr_hi`. A result equal to either threshold is inside the window.
- R4: With persistence 0, every accepted result raises the interrupt, whatever its value.
- R5: With persistence N from 1 to 15, the interrupt is raised on the result that completes a run of N consecutive out-of-window results, and on every further out-of-window result of that run. An in-window result restarts the run from zero.
- R6: Mode 00 never asserts the interrupt. Writing mode 00 drops any pending interrupt.
- R7: Mode 01 (level): `irq_n` goes low on the clock edge that takes the triggering result and stays low until `clr_cmd` is pulsed. `alert_ack` has no effect, and `alert_pend` stays 0.
- R8: Mode 10 (alert): the interrupt drives `irq_n` low and `alert_pend` high. Both are released only by `alert_ack`; `clr_cmd` has no effect.
- R9: A write that selects mode 11 asserts the interrupt and `alert_pend` on that write's edge. Mode 11 then behaves as alert mode and is cleared by `alert_ack`.
- R10: Any configuration write restarts the consecutive-result run. A result strobed in the same cycle as a write is discarded.
- R11: If an interrupt trigger and a clear arrive in the same cycle, the trigger wins and the interrupt stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: a conversion result is ready |
| res_data | input | 16 | Conversion result |
| thr_lo | input | 16 | Lower window bound |
| thr_hi | input | 16 | Upper window bound |
| ctl_wr | input | 1 | Configuration write strobe |
| ctl_wdata | input | 8 | Configuration write data |
| clr_cmd | input | 1 | Host clear command (level mode) |
| alert_ack | input | 1 | Alert-response transfer completed |
| ctl_q | output | 8 | Configuration register contents |
| irq_n | output | 1 | Active-low interrupt |
| alert_pend | output | 1 | Alert-style interrupt pending |

## Verification
A wrong run counter does not show at once. It shows as an interrupt that appears one or more results too early or too late, so the bench walks runs that are broken by exact-threshold values and by configuration writes, and checks `irq_n` on every edge. A wrong pending bit or mode decode shows on the edge right after the offending strobe: a clear that should be ignored releases the line, or a clear that should act leaves it low. For that reason every clear and acknowledge pulse is followed by a check on the next cycle in each of the modes.

// File: rtl/win_irq_pkg.sv
package win_irq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_LEVEL   = 2'b01,
    MODE_ALERT   = 2'b10,
    MODE_SWALERT = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/win_cmp.sv
module win_cmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic          outside
);
  logic below;
  logic above;

  always_comb begin
    below   = (sample < lo);
    above   = (sample > hi);
    outside = below | above;
  end
endmodule

// File: rtl/persist_ctr.sv
module persist_ctr #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic          outside,
  input  logic [PW-1:0] limit,
  output logic          hit
);
  localparam logic [PW-1:0] RUN_MAX = {PW{1'b1}};

  logic [PW-1:0] run_q;
  logic [PW-1:0] run_d;
  logic [PW-1:0] run_inc;

  always_comb begin
    run_inc = (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
    run_d   = run_q;
    hit     = 1'b0;
    if (restart) begin
      run_d = '0;
    end else if (step) begin
      run_d = outside ? run_inc : '0;
      if (limit == '0) begin
        hit = 1'b1;
      end else if (outside && (run_inc >= limit)) begin
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (restart || step) begin
      run_q <= run_d;
    end
  end

  // R10
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (run_q == '0));

  // R5
  inside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !outside && !restart) |=> (run_q == '0));
endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import win_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_mode_e mode,
  input  logic      cfg_wr,
  input  logic      hit,
  input  logic      sw_set,
  input  logic      force_off,
  input  logic      clr_cmd,
  input  logic      alert_ack,
  output logic      pend_q
);
  logic pend_d;
  logic alert_style;

  always_comb begin
    alert_style = (mode == MODE_ALERT) || (mode == MODE_SWALERT);
    pend_d      = pend_q;
    if ((mode == MODE_LEVEL) && clr_cmd) begin
      pend_d = 1'b0;
    end
    if (alert_style && alert_ack) begin
      pend_d = 1'b0;
    end
    if (hit && (mode != MODE_OFF)) begin
      pend_d = 1'b1;
    end
    if (sw_set) begin
      pend_d = 1'b1;
    end
    if (force_off) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> !pend_q);

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && (mode == MODE_LEVEL) && !clr_cmd && !cfg_wr) |=> pend_q);

  // R8
  alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && alert_style && !alert_ack && !cfg_wr) |=> pend_q);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (mode != MODE_OFF) && !cfg_wr) |=> pend_q);
endmodule

// File: rtl/win_irq_filter.sv
module win_irq_filter
  import win_irq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic [DW-1:0] thr_lo,
  input  logic [DW-1:0] thr_hi,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          clr_cmd,
  input  logic          alert_ack,
  output logic [7:0]    ctl_q,
  output logic          irq_n,
  output logic          alert_pend
);
  localparam int CW      = 8;
  localparam int PW      = 4;
  localparam int MODE_LO = PW;
  localparam int MODE_HI = PW + 1;
  localparam int USED    = MODE_HI + 1;

  logic [CW-1:0] cfg_q;
  logic [CW-1:0] cfg_d;
  irq_mode_e     mode_cur;
  irq_mode_e     mode_new;
  logic [PW-1:0] persist;
  logic          outside;
  logic          step;
  logic          hit;
  logic          pend;

  always_comb begin
    cfg_d = cfg_q;
    if (ctl_wr) begin
      cfg_d = {{(CW-USED){1'b0}}, ctl_wdata[USED-1:0]};
    end
    mode_cur = irq_mode_e'(cfg_q[MODE_HI:MODE_LO]);
    mode_new = irq_mode_e'(ctl_wdata[MODE_HI:MODE_LO]);
    persist  = cfg_q[PW-1:0];
    step     = res_valid && !ctl_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ctl_wr) begin
      cfg_q <= cfg_d;
    end
  end

  win_cmp #(.DW(DW)) u_cmp (
    .sample  (res_data),
    .lo      (thr_lo),
    .hi      (thr_hi),
    .outside (outside)
  );

  persist_ctr #(.PW(PW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctl_wr),
    .step    (step),
    .outside (outside),
    .limit   (persist),
    .hit     (hit)
  );

  irq_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_cur),
    .cfg_wr    (ctl_wr),
    .hit       (hit),
    .sw_set    (ctl_wr && (mode_new == MODE_SWALERT)),
    .force_off (ctl_wr && (mode_new == MODE_OFF)),
    .clr_cmd   (clr_cmd),
    .alert_ack (alert_ack),
    .pend_q    (pend)
  );

  always_comb begin
    ctl_q      = cfg_q;
    irq_n      = !pend;
    alert_pend = pend && ((mode_cur == MODE_ALERT) || (mode_cur == MODE_SWALERT));
  end

  // R4
  every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !ctl_wr && (persist == '0) && (mode_cur != MODE_OFF)) |=> !irq_n);

  // R9
  sw_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (ctl_wdata[MODE_HI:MODE_LO] == 2'b11)) |=> (!irq_n && alert_pend));

  // R8
  alert_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_pend |-> !irq_n);

  // R7
  level_no_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == MODE_LEVEL) |-> !alert_pend);
endmodule

// File: tb/sim_win_irq_filter.sv
module sim_win_irq_filter;
  logic        clk;
  logic        rst_n;
  logic        res_valid;
  logic [15:0] res_data;
  logic [15:0] thr_lo;
  logic [15:0] thr_hi;
  logic        ctl_wr;
  logic [7:0]  ctl_wdata;
  logic        clr_cmd;
  logic        alert_ack;
  logic [7:0]  ctl_q;
  logic        irq_n;
  logic        alert_pend;

  typedef struct {
    logic       irqn;
    logic       al;
    logic [7:0] ctl;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks;
  int   failures;
  bit   done;

  win_irq_filter #(.DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .clr_cmd(clr_cmd), .alert_ack(alert_ack), .ctl_q(ctl_q), .irq_n(irq_n),
    .alert_pend(alert_pend)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic compare(input exp_t e);
    checks++;
    if (irq_n !== e.irqn || alert_pend !== e.al || ctl_q !== e.ctl) begin
      failures++;
      $display("FAIL %s: irq_n=%b alert_pend=%b ctl_q=%h expected irq_n=%b alert_pend=%b ctl_q=%h",
               e.tag, irq_n, alert_pend, ctl_q, e.irqn, e.al, e.ctl);
    end
  endtask

  // Monitor: one expectation per clock edge, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      compare(exp_q.pop_front());
    end
  end

  // Driver: sets inputs at the falling edge and queues the result expected after the next rising edge
  task automatic step(input logic v, input logic [15:0] d, input logic w, input logic [7:0] wd,
                      input logic c, input logic a, input logic ei, input logic ea,
                      input logic [7:0] ec, input string tag);
    exp_t e;
    @(negedge clk);
    res_valid = v; res_data = d; ctl_wr = w; ctl_wdata = wd;
    clr_cmd = c; alert_ack = a;
    e.irqn = ei; e.al = ea; e.ctl = ec; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    exp_t r;
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; res_valid = 0; res_data = '0; ctl_wr = 0; ctl_wdata = '0;
    clr_cmd = 0; alert_ack = 0; thr_lo = 16'd100; thr_hi = 16'd200;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    r.irqn = 1'b1; r.al = 1'b0; r.ctl = 8'h00; r.tag = "R1";
    compare(r);

    // R2: reserved bits dropped, level mode with persistence 7
    step(0, 0,   1, 8'hD7, 0, 0, 1, 0, 8'h17, "R2");
    step(0, 0,   1, 8'h10, 0, 0, 1, 0, 8'h10, "R2");
    // R4: persistence 0 fires on an in-window result
    step(1, 150, 0, 0,     0, 0, 0, 0, 8'h10, "R4");
    // R7: ack ignored in level mode, clear releases
    step(0, 0,   0, 0,     0, 1, 0, 0, 8'h10, "R7");
    step(0, 0,   0, 0,     0, 0, 0, 0, 8'h10, "R7");
    step(0, 0,   0, 0,     1, 0, 1, 0, 8'h10, "R7");
    // R3 / R5: persistence 3, exact thresholds break the run
    step(0, 0,   1, 8'h13, 0, 0, 1, 0, 8'h13, "R2");
    step(1, 99,  0, 0,     0, 0, 1, 0, 8'h13, "R5");
    step(1, 201, 0, 0,     0, 0, 1, 0, 8'h13, "R5");
    step(1, 100, 0, 0,     0, 0, 1, 0, 8'h13, "R3");
    step(1, 200, 0, 0,     0, 0, 1, 0, 8'h13, "R3");
    step(1, 50,  0, 0,     0, 0, 1, 0, 8'h13, "R5");
    step(1, 250, 0, 0,     0, 0, 1, 0, 8'h13, "R5");
    step(1, 0,   0, 0,     0, 0, 0, 0, 8'h13, "R5");
    step(0, 0,   0, 0,     1, 0, 1, 0, 8'h13, "R7");
    // R5: longer run keeps firing
    step(1, 300, 0, 0,     0, 0, 0, 0, 8'h13, "R5");
    // R11: trigger and clear together
    step(1, 300, 0, 0,     1, 0, 0, 0, 8'h13, "R11");
    step(0, 0,   0, 0,     1, 0, 1, 0, 8'h13, "R7");
    // R10: a write restarts the run, a result during a write is discarded
    step(0, 0,   1, 8'h13, 0, 0, 1, 0, 8'h13, "R10");
    step(1, 10,  0, 0,     0, 0, 1, 0, 8'h13, "R10");
    step(1, 10,  0, 0,     0, 0, 1, 0, 8'h13, "R10");
    step(1, 10,  1, 8'h13, 0, 0, 1, 0, 8'h13, "R10");
    step(1, 10,  0, 0,     0, 0, 1, 0, 8'h13, "R10");
    step(1, 10,  0, 0,     0, 0, 1, 0, 8'h13, "R10");
    step(1, 10,  0, 0,     0, 0, 0, 0, 8'h13, "R10");
    step(0, 0,   0, 0,     1, 0, 1, 0, 8'h13, "R7");
    // R8: alert mode, persistence 2
    step(0, 0,   1, 8'h22, 0, 0, 1, 0, 8'h22, "R8");
    step(1, 500, 0, 0,     0, 0, 1, 0, 8'h22, "R8");
    step(1, 500, 0, 0,     0, 0, 0, 1, 8'h22, "R8");
    step(0, 0,   0, 0,     1, 0, 0, 1, 8'h22, "R8");
    step(0, 0,   0, 0,     0, 1, 1, 0, 8'h22, "R8");
    // R9: software-forced alert
    step(0, 0,   1, 8'h30, 0, 0, 0, 1, 8'h30, "R9");
    step(0, 0,   0, 0,     1, 0, 0, 1, 8'h30, "R9");
    step(0, 0,   0, 0,     0, 1, 1, 0, 8'h30, "R9");
    // R6: off mode stays quiet, writing off drops a pending interrupt
    step(0, 0,   1, 8'h01, 0, 0, 1, 0, 8'h01, "R6");
    step(1, 999, 0, 0,     0, 0, 1, 0, 8'h01, "R6");
    step(0, 0,   1, 8'h10, 0, 0, 1, 0, 8'h10, "R6");
    step(1, 150, 0, 0,     0, 0, 0, 0, 8'h10, "R6");
    step(0, 0,   1, 8'h00, 0, 0, 1, 0, 8'h00, "R6");
    step(1, 999, 0, 0,     0, 0, 1, 0, 8'h00, "R6");
    step(0, 0,   0, 0,     0, 0, 1, 0, 8'h00, "R6");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule